// File: doc/BRIEF.md
# Serial Clock and Chip-Select Window Sequencer

This block produces the serial bit clock and the chip-select window for one transfer on a serial peripheral bus. A table of per-target settings arrives as parallel inputs: for each target, one 32-bit word holds a rate code, a lead count, a lag count and a gap count, and two side vectors hold each target's clock polarity and clock phase. On a start pulse the block latches the entry picked by the target-select input. It then opens the chip-select window and toggles the serial clock for the requested number of bits, giving a sample strobe and a launch strobe on the proper edges. It closes the window after the lag time, keeps it closed for the gap time, and pulses a done flag. The data shifter that uses the strobes is outside this block.

All timing is counted in half bit periods of H input clocks. H is 256 divided by the rate code, so a full bit period is 512/code input clocks. This gives serial clocks from the input clock divided by 4 (code 128) down to divided by 512 (code 1).

The controller has five states. IDLE goes to LEAD on an accepted start. LEAD goes to SHIFT when the lead time has run out. SHIFT goes to LAG after the last clock edge. LAG goes to GAP when the lag time has run out, and this transition closes the window. GAP goes back to IDLE when the gap time ends, and this transition raises done. A phase with a count of N lasts 2·N·H input clocks, or a single clock when N is zero.

Top module: `spi_cs_timer`

## Requirements
- R1: After reset, cs_active, busy, done, sample_stb and shift_stb are low and sclk is at the idle level of the selected target (0 when that polarity bit is 0).
- R2: The settings word of target d sits at dev_words[32·d+31 : 32·d], with the rate code in bits 31:24, lead in 23:16, lag in 15:8 and gap in 7:0. The entry, the polarity, the phase and bit_count are all latched at the accepted start. Later changes to the table, dev_sel or bit_count have no effect until done.
- R3: For a rate code that is a power of two from 1 to 128, one half period H is 256/code input clocks, and successive sclk edges within a transfer are H clocks apart.
- R4: A rate code of zero, or one that is not a power of two, is treated as code 1 (H = 256).
- R5: cs_active rises in the clock after the start is accepted. The first sclk edge follows it by (2·lead+1)·H clocks, or by H+1 clocks when lead is 0, and sclk does not move before that edge.
- R6: A transfer of B bits gives exactly 2·B sclk edges; B = 0 gives none, and then the window lasts (lead phase) + 1 + (lag phase) clocks.
- R7: sclk rests at the target's polarity level whenever the window is closed, and it returns to that level after the last edge.
- R8: With phase 0, sample_stb pulses on edges 1, 3, 5, … (leading) and shift_stb on edges 2, 4, …. With phase 1 the two are swapped. Each strobe coincides with its edge, gives B pulses per transfer and occurs only inside the window.
- R9: cs_active falls 2·lag·H clocks after the last sclk edge, or 1 clock after it when lag is 0.
- R10: done is a one-clock pulse 2·gap·H clocks after cs_active falls (1 clock when gap is 0), and busy is low in the same clock.
- R11: A start while busy is ignored: no second window opens and only one done pulse appears.
- R12: While idle, sclk follows the polarity bit of the current dev_sel, one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| dev_sel | input | SEL_W (3) | Target select |
| dev_words | input | NUM_DEV·32 (256) | Packed per-target settings words |
| cpol_vec | input | NUM_DEV (8) | Per-target clock polarity |
| cpha_vec | input | NUM_DEV (8) | Per-target clock phase |
| bit_count | input | LEN_W (8) | Number of bits in the transfer |
| busy | output | 1 | High from an accepted start until done |
| cs_active | output | 1 | Chip-select window open |
| sclk | output | 1 | Serial bit clock |
| sample_stb | output | 1 | One-clock pulse on each sampling edge |
| shift_stb | output | 1 | One-clock pulse on each launch edge |
| done | output | 1 | One-clock pulse when the gap ends |

## Verification
The bench measures the time from window open to first edge, the edge spacing, the time from last edge to window close, and the time from window close to done. It does this for several rate codes, for zero lead, lag and gap counts, and for a zero-bit transfer. An off-by-one in the phase counters shows up as a timing one clock or one half period off. Treating an illegal rate code as anything other than divide by 512 gives edge spacing far from 256 clocks. A swapped phase decode puts the sample strobes on even edges instead of odd ones. A design that accepts a second start, or that reads the table live instead of latching it, opens a second window or changes the timing partway through.

// File: rtl/spi_cs_timer_pkg.sv
package spi_cs_timer_pkg;

    localparam int FLD_W  = 8;
    localparam int WORD_W = 4 * FLD_W;
    localparam int HW     = FLD_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_LAG,
        ST_GAP
    } tim_state_t;

    // Field order matters: software packs words as code, lead, lag, gap (MSB first).
    typedef struct packed {
        logic [FLD_W-1:0] rate_code;
        logic [FLD_W-1:0] lead_cnt;
        logic [FLD_W-1:0] lag_cnt;
        logic [FLD_W-1:0] gap_cnt;
    } dev_cfg_t;

    // Half bit period minus one, in input clocks: 256/code - 1; illegal codes use code 1.
    function automatic logic [HW-1:0] half_m1_of(input logic [FLD_W-1:0] code);
        logic [HW-1:0] h;
        h = HW'(1) << FLD_W;
        if ((code != '0) && ((code & (code - 1'b1)) == '0)) begin
            for (int i = 0; i < FLD_W; i++) begin
                if (code[i]) h = HW'(1) << (FLD_W - i);
            end
        end
        return h - HW'(1);
    endfunction

endpackage

// File: rtl/sct_cfg_pick.sv
module sct_cfg_pick
    import spi_cs_timer_pkg::*;
#(
    parameter int NUM_DEV = 8,
    parameter int SEL_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_DEV*WORD_W-1:0] dev_words,
    input  logic [NUM_DEV-1:0]        cpol_vec,
    input  logic [NUM_DEV-1:0]        cpha_vec,
    input  logic [SEL_W-1:0]          dev_sel,
    output dev_cfg_t                  sel_cfg,
    output logic [HW-1:0]             sel_half_m1,
    output logic                      sel_cpol,
    output logic                      sel_cpha
);
    localparam int DEPTH = 1 << SEL_W;

    dev_cfg_t           tbl [DEPTH];
    logic [DEPTH-1:0]   pol_pad;
    logic [DEPTH-1:0]   pha_pad;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
            if (g < NUM_DEV) begin : g_real
                assign tbl[g]     = dev_cfg_t'(dev_words[g*WORD_W +: WORD_W]);
                assign pol_pad[g] = cpol_vec[g];
                assign pha_pad[g] = cpha_vec[g];
            end else begin : g_pad
                assign tbl[g]     = '0;
                assign pol_pad[g] = 1'b0;
                assign pha_pad[g] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        sel_cfg     = tbl[dev_sel];
        sel_cpol    = pol_pad[dev_sel];
        sel_cpha    = pha_pad[dev_sel];
        sel_half_m1 = half_m1_of(sel_cfg.rate_code);
    end

    logic [HW:0] half_full;
    assign half_full = {1'b0, sel_half_m1} + (HW+1)'(1);

    AST_HALF_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(half_full) && (half_full >= (HW+1)'(2))) // R3
        else $error("half period not a power of two");

endmodule

// File: rtl/sct_half_tick.sv
module sct_half_tick
    import spi_cs_timer_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [HW-1:0] half_m1,
    output logic          tick
);
    logic [HW-1:0] pre;

    assign tick = (pre == half_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pre <= '0;
        else if (clear || tick)  pre <= '0;
        else                     pre <= pre + HW'(1);
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pre <= half_m1) // R3
        else $error("prescaler past its limit");

endmodule

// File: rtl/spi_cs_timer.sv
module spi_cs_timer
    import spi_cs_timer_pkg::*;
#(
    parameter int  NUM_DEV = 8,
    parameter int  LEN_W   = 8,
    localparam int SEL_W   = $clog2(NUM_DEV)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [SEL_W-1:0]          dev_sel,
    input  logic [NUM_DEV*WORD_W-1:0] dev_words,
    input  logic [NUM_DEV-1:0]        cpol_vec,
    input  logic [NUM_DEV-1:0]        cpha_vec,
    input  logic [LEN_W-1:0]          bit_count,
    output logic                      busy,
    output logic                      cs_active,
    output logic                      sclk,
    output logic                      sample_stb,
    output logic                      shift_stb,
    output logic                      done
);
    localparam int CW = ((LEN_W > FLD_W) ? LEN_W : FLD_W) + 1;

    tim_state_t        state, nxt;
    dev_cfg_t          sel_cfg;
    logic [HW-1:0]     sel_half_m1, half_m1_q;
    logic              sel_cpol, sel_cpha, cpol_q, cpha_q;
    logic [FLD_W-1:0]  lag_q, gap_q;
    logic [LEN_W-1:0]  bits_q;
    logic [CW-1:0]     cnt, load_val;
    logic              tick, adv, clear, lead;

    sct_cfg_pick #(.NUM_DEV(NUM_DEV), .SEL_W(SEL_W)) u_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_words   (dev_words),
        .cpol_vec    (cpol_vec),
        .cpha_vec    (cpha_vec),
        .dev_sel     (dev_sel),
        .sel_cfg     (sel_cfg),
        .sel_half_m1 (sel_half_m1),
        .sel_cpol    (sel_cpol),
        .sel_cpha    (sel_cpha)
    );

    sct_half_tick u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .half_m1 (half_m1_q),
        .tick    (tick)
    );

    // Phase ends at zero count, or on the tick that spends the last half period.
    always_comb begin
        adv  = (cnt == '0) || ((cnt == CW'(1)) && tick);
        nxt  = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_LEAD;
            ST_LEAD:  if (adv)   nxt = ST_SHIFT;
            ST_SHIFT: if (adv)   nxt = ST_LAG;
            ST_LAG:   if (adv)   nxt = ST_GAP;
            ST_GAP:   if (adv)   nxt = ST_IDLE;
            default:             nxt = ST_IDLE;
        endcase
    end

    assign clear = (state == ST_IDLE) || adv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        unique case (state)
            ST_LEAD:  load_val = CW'(bits_q) << 1;
            ST_SHIFT: load_val = CW'(lag_q) << 1;
            ST_LAG:   load_val = CW'(gap_q) << 1;
            default:  load_val = '0;
        endcase
    end

    // Settings are captured once per transfer; counts are in half bit periods.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            half_m1_q <= '0;
            lag_q     <= '0;
            gap_q     <= '0;
            bits_q    <= '0;
            cpol_q    <= 1'b0;
            cpha_q    <= 1'b0;
        end else if (state == ST_IDLE) begin
            if (start) begin
                cnt       <= CW'(sel_cfg.lead_cnt) << 1;
                half_m1_q <= sel_half_m1;
                lag_q     <= sel_cfg.lag_cnt;
                gap_q     <= sel_cfg.gap_cnt;
                bits_q    <= bit_count;
                cpol_q    <= sel_cpol;
                cpha_q    <= sel_cpha;
            end
        end else if (adv) begin
            cnt <= load_val;
        end else if (tick) begin
            cnt <= cnt - CW'(1);
        end
    end

    // An even remaining count at a tick marks the leading edge of a bit.
    assign lead = ~cnt[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk       <= 1'b0;
            sample_stb <= 1'b0;
            shift_stb  <= 1'b0;
            done       <= 1'b0;
        end else begin
            sample_stb <= 1'b0;
            shift_stb  <= 1'b0;
            done       <= 1'b0;
            unique case (state)
                ST_IDLE: sclk <= sel_cpol;
                ST_SHIFT: begin
                    if (tick && (cnt != '0)) begin
                        sclk       <= ~sclk;
                        sample_stb <= lead ^ cpha_q;
                        shift_stb  <= ~(lead ^ cpha_q);
                    end
                end
                ST_GAP: begin
                    sclk <= cpol_q;
                    if (adv) done <= 1'b1;
                end
                default: sclk <= cpol_q;
            endcase
        end
    end

    always_comb begin
        cs_active = (state == ST_LEAD) || (state == ST_SHIFT) || (state == ST_LAG);
        busy      = (state != ST_IDLE);
    end

    AST_STB_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb || shift_stb) |-> cs_active) // R8
        else $error("strobe outside window");

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && shift_stb)) // R8
        else $error("both strobes at once");

    AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> (sclk == cpol_q)) // R7
        else $error("sclk off its rest level");

    AST_NO_EDGE_IN_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_LEAD) && ($past(state) == ST_LEAD)) |-> $stable(sclk)) // R5
        else $error("sclk moved during lead");

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) // R10
        else $error("done longer than one clock");

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !cs_active)) // R10
        else $error("done while busy");

endmodule

// File: tb/spi_cs_timer_bench.sv
module spi_cs_timer_bench;
    localparam int ND = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [2:0]     dev_sel = '0;
    logic [ND*32-1:0] dev_words = '0;
    logic [ND-1:0]  cpol_vec = '0;
    logic [ND-1:0]  cpha_vec = '0;
    logic [7:0]     bit_count = '0;
    logic           busy, cs_active, sclk, sample_stb, shift_stb, done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    spi_cs_timer u_spi_cs_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .dev_sel(dev_sel),
        .dev_words(dev_words), .cpol_vec(cpol_vec), .cpha_vec(cpha_vec),
        .bit_count(bit_count), .busy(busy), .cs_active(cs_active), .sclk(sclk),
        .sample_stb(sample_stb), .shift_stb(shift_stb), .done(done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog act=%0d exp<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Monitor: samples at the falling edge, cleared by mon_clr driven at rising edges.
    logic mon_clr = 1'b0;
    bit   exp_pha = 1'b0;
    logic prev_cs = 1'b0, prev_sclk = 1'b0;
    int m_rise, m_fall, m_first, m_last, m_edges, m_samp, m_shft, m_bad, m_done_t, m_done_n, m_rises;

    always @(negedge clk) begin
        bit tog;
        if (mon_clr) begin
            m_rise = -1; m_fall = -1; m_first = -1; m_last = -1; m_edges = 0;
            m_samp = 0; m_shft = 0; m_bad = 0; m_done_t = -1; m_done_n = 0; m_rises = 0;
        end else begin
            tog = cs_active && (sclk != prev_sclk);
            if (cs_active && !prev_cs) begin m_rise = cyc; m_rises++; end
            if (!cs_active && prev_cs) m_fall = cyc;
            if (tog) begin
                m_edges++;
                if (m_edges == 1) m_first = cyc;
                m_last = cyc;
            end
            if (sample_stb) begin
                m_samp++;
                if (!(tog && (((m_edges % 2) == 1) == (exp_pha == 1'b0)))) m_bad++;
            end
            if (shift_stb) begin
                m_shft++;
                if (!(tog && (((m_edges % 2) == 1) != (exp_pha == 1'b0)))) m_bad++;
            end
            if (done) begin m_done_n++; m_done_t = cyc; end
        end
        prev_cs   = cs_active;
        prev_sclk = sclk;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic mon_reset();
        @(posedge clk); mon_clr = 1'b1;
        @(posedge clk); mon_clr = 1'b0;
    endtask

    function automatic int half_of(input int code);
        int h;
        h = 256;
        if (code > 0 && code < 256 && ((code & (code - 1)) == 0)) h = 256 / code;
        return h;
    endfunction

    // One transfer; disturb=1 pokes start, dev_sel, table and length mid-flight.
    task automatic run_xfer(input int dev, input int code, input int su, input int lg,
                            input int gp, input int bits, input bit pol, input bit pha,
                            input bit disturb);
        int h, n, e_r2f, e_f2l, e_l2c, e_c2d;
        @(negedge clk);
        dev_words[dev*32 +: 32] = {8'(code), 8'(su), 8'(lg), 8'(gp)};
        cpol_vec[dev] = pol;
        cpha_vec[dev] = pha;
        dev_sel = 3'(dev);
        bit_count = 8'(bits);
        exp_pha = pha;
        mon_reset();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (disturb) begin
            step(); step();
            @(negedge clk);
            start = 1'b1;
            dev_sel = 3'((dev + 1) % ND);
            dev_words[dev*32 +: 32] = {8'd1, 8'd7, 8'd7, 8'd7};
            cpha_vec[dev] = ~pha;
            bit_count = 8'(bits + 3);
            @(negedge clk); start = 1'b0;
        end
        n = 0;
        while (m_done_n == 0 && n < 40000) begin step(); n++; end
        chk(n < 40000, "R10", "done timeout", n, 0);
        for (int k = 0; k < 12; k++) step();
        h = half_of(code);
        e_r2f = (su > 0) ? (2*su + 1)*h : h + 1;
        e_f2l = (2*bits - 1)*h;
        e_l2c = (lg > 0) ? 2*lg*h : 1;
        e_c2d = (gp > 0) ? 2*gp*h : 1;
        if (bits > 0) begin
            chk(m_first - m_rise == e_r2f, "R5", "cs rise to first edge", m_first - m_rise, e_r2f);
            chk(m_last - m_first == e_f2l, "R3", "first to last edge", m_last - m_first, e_f2l);
            chk(m_fall - m_last == e_l2c, "R9", "last edge to cs fall", m_fall - m_last, e_l2c);
        end else begin
            e_r2f = ((su > 0) ? 2*su*h : 1) + 1 + e_l2c;
            chk(m_fall - m_rise == e_r2f, "R6", "zero-bit window", m_fall - m_rise, e_r2f);
        end
        chk(m_done_t - m_fall == e_c2d, "R10", "cs fall to done", m_done_t - m_fall, e_c2d);
        chk(m_edges == 2*bits, "R6", "edge count", m_edges, 2*bits);
        chk(m_samp == bits && m_shft == bits, "R8", "strobe counts", m_samp + m_shft, 2*bits);
        chk(m_bad == 0, "R8", "strobes on wrong edges", m_bad, 0);
        chk(m_rises == 1 && m_done_n == 1, disturb ? "R11" : "R2", "windows and done pulses",
            m_rises*10 + m_done_n, 11);
        chk(sclk == pol && !busy, "R7", "sclk rest after done", int'(sclk), int'(pol));
    endtask

    task automatic t_reset();
        step();
        chk(!cs_active && !busy && !done && !sample_stb && !shift_stb && !sclk, "R1",
            "outputs after reset", int'({cs_active, busy, done, sample_stb, shift_stb, sclk}), 0);
    endtask

    task automatic t_mode0_fast();   run_xfer(2, 128, 2, 1, 3, 4, 1'b0, 1'b0, 1'b0); endtask
    task automatic t_mode3();        run_xfer(5, 64, 1, 2, 1, 3, 1'b1, 1'b1, 1'b0); endtask
    task automatic t_mode1_slow();   run_xfer(0, 16, 1, 1, 1, 2, 1'b0, 1'b1, 1'b0); endtask
    task automatic t_code_zero();    run_xfer(3, 0, 1, 0, 0, 1, 1'b0, 1'b0, 1'b0); endtask  // R4
    task automatic t_code_npow2();   run_xfer(6, 96, 0, 1, 0, 1, 1'b1, 1'b0, 1'b0); endtask // R4
    task automatic t_zero_counts();  run_xfer(1, 128, 0, 0, 0, 2, 1'b0, 1'b0, 1'b0); endtask
    task automatic t_zero_bits();    run_xfer(4, 128, 1, 1, 2, 0, 1'b1, 1'b0, 1'b0); endtask // R6
    task automatic t_busy_start();   run_xfer(7, 32, 2, 1, 1, 3, 1'b0, 1'b0, 1'b1); endtask // R11 R2

    task automatic t_idle_pol();
        @(negedge clk);
        cpol_vec = 8'b1010_0110;
        dev_sel = 3'd1;
        step(); step();
        chk(sclk == 1'b1, "R12", "idle sclk dev1", int'(sclk), 1);
        @(negedge clk);
        dev_sel = 3'd3;
        step(); step();
        chk(sclk == 1'b0, "R12", "idle sclk dev3", int'(sclk), 0);
        chk(!cs_active && !busy, "R12", "no window while idle", int'(cs_active), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mode0_fast();
        t_mode3();
        t_mode1_slow();
        t_code_zero();
        t_code_npow2();
        t_zero_counts();
        t_zero_bits();
        t_busy_start();
        t_idle_pol();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule